// File: doc/BRIEF.md
# Dual-Clock Word Buffer with Programmable Level Flags

This block carries 18-bit words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`. It forms one direction of a bidirectional link. Storage is a simple dual-port array of `DEPTH` words (256 or 512) that maps onto block RAM. Each side keeps its own binary pointer. A pointer crosses to the other clock as Gray code through a two-stage synchroniser. Four active-low status outputs report the fill level: empty and almost-empty are computed in the read domain, and full and almost-full are computed in the write domain.

Two thresholds set where the almost-flags switch. The host loads them at run time through a load strobe on the write clock. Both thresholds return to 8 on reset. Reset is a request: it is honoured only while the host select and both port enables are inactive. Until the first honoured reset after power-up, the block refuses every write.

Top module: `dcf_fifo_dir`

## Requirements
- R1: A reset takes effect only while `rst_n` is low and `host_cs_n`, `wr_en_n` and `rd_en_n` are all high. A low `rst_n` while `host_cs_n` is low leaves the stored words and flags untouched.
- R2: After a reset, `empty_n` and `almost_empty_n` are 0 (asserted), and `full_n` and `almost_full_n` are 1 (deasserted). Both pointers return to location 0.
- R3: After a reset, both the almost-empty offset and the almost-full offset are 8.
- R4: Before the first honoured reset after power-up, no write is stored.
- R5: Words leave in the order they were written. A read accepted on a `rd_clk` rising edge (`rd_en_n` low, `empty_n` high) places its word on `rd_data` at that edge. `rd_data` holds while `rd_en_n` is high.
- R6: `full_n` goes low once `DEPTH` words are stored, and it is high at `DEPTH`-1 words.
- R7: A write attempted while `full_n` is low is discarded and does not move the write pointer.
- R8: A read attempted while `empty_n` is low is discarded and does not move the read pointer.
- R9: `almost_empty_n` is low exactly when the stored count is at most the almost-empty offset.
- R10: `almost_full_n` is low exactly when the free space (`DEPTH` minus the stored count) is at most the almost-full offset.
- R11: On a `wr_clk` edge with `off_load` high, `off_val` is loaded into the almost-empty offset when `off_sel` is 0, or into the almost-full offset when `off_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Reset request, active low, qualified |
| host_cs_n | input | 1 | Host select, active low; must be high for reset |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DW (18) | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DW (18) | Registered word read out |
| off_load | input | 1 | Threshold load strobe (write clock) |
| off_sel | input | 1 | 0 = almost-empty offset, 1 = almost-full offset |
| off_val | input | PW (AW+1) | Threshold value to load |
| empty_n | output | 1 | Low when nothing is stored |
| almost_empty_n | output | 1 | Low when count is at most the almost-empty offset |
| full_n | output | 1 | Low when DEPTH words are stored |
| almost_full_n | output | 1 | Low when free space is at most the almost-full offset |

## Verification
A write moves `full_n` and `almost_full_n` at the same `wr_clk` edge. It reaches `empty_n` and `almost_empty_n` on the third `rd_clk` edge: two synchroniser stages, then the flag register. Reads act on the full-side flags with the same three-edge delay in the write domain. An honoured reset lands two edges after the request in each domain. A read's word appears on `rd_data` at the accepting edge. The scoreboard monitor therefore decides at each `rd_clk` falling edge whether the next rising edge reads, and it compares `rd_data` at the falling edge that follows. Every flag check waits at least eight edges of both clocks after the last stimulus, which clears the worst three-edge path.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int unsigned WORD_W      = 18;
  localparam int unsigned OFF_DEFAULT = 8;
  typedef enum logic { OFF_AE = 1'b0, OFF_AF = 1'b1 } off_sel_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int         W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1 = INIT;
  logic [W-1:0] stg2 = INIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1 <= INIT;
      stg2 <= INIT;
    end else begin
      stg1 <= d;
      stg2 <= stg1;
    end
  end

  assign q = stg2;
endmodule

// File: rtl/dcf_g2b.sv
`timescale 1ns/1ps
module dcf_g2b #(
  parameter int W = 9
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^(gray >> i);
  end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [0:WORDS-1];
  logic [DW-1:0] rdata_q = '0;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic          off_load,
  input  off_sel_e      off_sel,
  input  logic [PW-1:0] off_val,
  input  logic [PW-1:0] rgray_s,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] ae_off,
  output logic          full_n,
  output logic          almost_full_n
);
  localparam logic [PW-1:0] CAP     = PW'(DEPTH);
  localparam logic [PW-1:0] OFF_RST = PW'(OFF_DEFAULT);

  logic          armed    = 1'b0;
  logic [PW-1:0] wbin     = '0;
  logic [PW-1:0] wgray_q  = '0;
  logic [PW-1:0] ae_off_q = OFF_RST;
  logic [PW-1:0] af_off_q = OFF_RST;
  logic          full_n_q = 1'b1;
  logic          af_n_q   = 1'b1;

  logic [PW-1:0] rbin, wnext, fill_nx, free_nx;
  logic          fire;

  dcf_g2b #(.W(PW)) u_g2b (.gray(rgray_s), .bin(rbin));

  always_comb begin
    fire    = armed & ~wr_en_n & full_n_q & ~rst;
    wnext   = wbin + {{(PW-1){1'b0}}, fire};
    fill_nx = wnext - rbin;
    free_nx = CAP - fill_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b1;
      wbin     <= '0;
      wgray_q  <= '0;
      ae_off_q <= OFF_RST;
      af_off_q <= OFF_RST;
      full_n_q <= 1'b1;
      af_n_q   <= 1'b1;
    end else begin
      wbin     <= wnext;
      wgray_q  <= wnext ^ (wnext >> 1);
      full_n_q <= (fill_nx != CAP);
      af_n_q   <= (free_nx > af_off_q);
      if (off_load) begin
        if (off_sel == OFF_AE) ae_off_q <= off_val;
        else                   af_off_q <= off_val;
      end
    end
  end

  assign wr_fire       = fire;
  assign waddr         = wbin[AW-1:0];
  assign wgray         = wgray_q;
  assign ae_off        = ae_off_q;
  assign full_n        = full_n_q;
  assign almost_full_n = af_n_q;

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !full_n_q && !wr_en_n) |=> (wbin == $past(wbin)));

  // R4
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !armed) |=> (wbin == $past(wbin)));

  // R10
  full_implies_af_chk: assert property (@(posedge clk) disable iff (rst)
    !full_n_q |-> !af_n_q);
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int AW = 8,
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en_n,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] ae_off_s,
  output logic          rd_fire,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty_n,
  output logic          almost_empty_n
);
  logic [PW-1:0] rbin      = '0;
  logic [PW-1:0] rgray_q   = '0;
  logic          empty_n_q = 1'b0;
  logic          ae_n_q    = 1'b0;

  logic [PW-1:0] wbin, rnext, fill_nx;
  logic          fire;

  dcf_g2b #(.W(PW)) u_g2b (.gray(wgray_s), .bin(wbin));

  always_comb begin
    fire    = ~rd_en_n & empty_n_q & ~rst;
    rnext   = rbin + {{(PW-1){1'b0}}, fire};
    fill_nx = wbin - rnext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin      <= '0;
      rgray_q   <= '0;
      empty_n_q <= 1'b0;
      ae_n_q    <= 1'b0;
    end else begin
      rbin      <= rnext;
      rgray_q   <= rnext ^ (rnext >> 1);
      empty_n_q <= (fill_nx != '0);
      ae_n_q    <= (fill_nx > ae_off_s);
    end
  end

  assign rd_fire        = fire;
  assign raddr          = rbin[AW-1:0];
  assign rgray          = rgray_q;
  assign empty_n        = empty_n_q;
  assign almost_empty_n = ae_n_q;

  // R8
  no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !empty_n_q && !rd_en_n) |=> (rbin == $past(rbin)));
endmodule

// File: rtl/dcf_fifo_dir.sv
`timescale 1ns/1ps
module dcf_fifo_dir
  import dcf_pkg::*;
#(
  parameter  int DEPTH = 256,
  parameter  int DW    = WORD_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          host_cs_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  output logic [DW-1:0] rd_data,
  input  logic          off_load,
  input  logic          off_sel,
  input  logic [PW-1:0] off_val,
  output logic          empty_n,
  output logic          almost_empty_n,
  output logic          full_n,
  output logic          almost_full_n
);
  localparam logic [PW-1:0] OFF_RST = PW'(OFF_DEFAULT);

  logic          rst_qual, wr_rst, rd_rst;
  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [PW-1:0] ae_off_w, ae_off_r;
  off_sel_e      sel_e;

  assign rst_qual = ~rst_n & host_cs_n & wr_en_n & rd_en_n;
  assign sel_e    = off_sel_e'(off_sel);

  dcf_sync #(.W(1), .INIT(1'b0)) u_wrst (
    .clk(wr_clk), .rst(1'b0), .d(rst_qual), .q(wr_rst));
  dcf_sync #(.W(1), .INIT(1'b0)) u_rrst (
    .clk(rd_clk), .rst(1'b0), .d(rst_qual), .q(rd_rst));

  dcf_sync #(.W(PW), .INIT('0)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(PW), .INIT('0)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(PW), .INIT(OFF_RST)) u_aeoff (
    .clk(rd_clk), .rst(rd_rst), .d(ae_off_w), .q(ae_off_r));

  dcf_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_en_n(wr_en_n),
    .off_load(off_load), .off_sel(sel_e), .off_val(off_val),
    .rgray_s(rgray_s), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .ae_off(ae_off_w), .full_n(full_n), .almost_full_n(almost_full_n));

  dcf_rd_side #(.AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .rd_en_n(rd_en_n),
    .wgray_s(wgray_s), .ae_off_s(ae_off_r), .rd_fire(rd_fire),
    .raddr(raddr), .rgray(rgray), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_fire), .raddr(raddr), .rdata(rd_data));

  // R5
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!rd_rst && rd_en_n) |=> $stable(rd_data));
endmodule

// File: tb/dcf_fifo_dir_test.sv
`timescale 1ns/1ps
module dcf_fifo_dir_test;
  localparam int DEPTH = 256;
  localparam int DW    = 18;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          rst_n = 1'b1, host_cs_n = 1'b1;
  logic          wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          off_load = 1'b0, off_sel = 1'b0;
  logic [PW-1:0] off_val = '0;
  logic          empty_n, almost_empty_n, full_n, almost_full_n;

  int            errors = 0, checks = 0, pops = 0;
  bit            done = 1'b0, pend = 1'b0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] next_word = 18'h00A5;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dcf_fifo_dir #(.DEPTH(DEPTH)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .host_cs_n(host_cs_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .off_load(off_load), .off_sel(off_sel), .off_val(off_val),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .full_n(full_n), .almost_full_n(almost_full_n));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Scoreboard monitor: decide at a falling edge, compare after the rising edge.
  always @(negedge rd_clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word", int'(rd_data), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R5 order", int'(rd_data), int'(e));
        pops++;
      end
    end
    pend = !rd_en_n && empty_n;
  end

  task automatic wr_burst(input int n, input bit keep);
    for (int i = 0; i < n; i++) begin
      @(posedge wr_clk); #1;
      wr_en_n = 1'b0;
      wr_data = next_word;
      if (keep) exp_q.push_back(next_word);
      next_word = next_word + 18'h0137;
    end
    @(posedge wr_clk); #1;
    wr_en_n = 1'b1;
  endtask

  task automatic rd_drain(input int n);
    @(posedge rd_clk); #1;
    rd_en_n = 1'b0;
    repeat (n) @(posedge rd_clk);
    #1;
    rd_en_n = 1'b1;
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
    #1;
  endtask

  task automatic do_reset(input logic cs_n);
    @(posedge wr_clk); #1;
    host_cs_n = cs_n;
    rst_n     = 1'b0;
    repeat (6) @(posedge rd_clk);
    #1;
    rst_n     = 1'b1;
    host_cs_n = 1'b1;
    settle();
  endtask

  task automatic load_off(input logic sel, input int v);
    @(posedge wr_clk); #1;
    off_load = 1'b1; off_sel = sel; off_val = PW'(v);
    @(posedge wr_clk); #1;
    off_load = 1'b0;
    settle();
  endtask

  initial begin
    settle();
    // R4: writes before any reset are refused
    wr_burst(3, 1'b0);
    settle();
    chk(empty_n == 1'b0, "R4 empty before reset", empty_n, 0);

    do_reset(1'b1);
    chk(empty_n == 1'b0,        "R2 empty_n", empty_n, 0);
    chk(almost_empty_n == 1'b0, "R2 almost_empty_n", almost_empty_n, 0);
    chk(full_n == 1'b1,         "R2 full_n", full_n, 1);
    chk(almost_full_n == 1'b1,  "R2 almost_full_n", almost_full_n, 1);

    // R3 / R9: default almost-empty offset of 8
    wr_burst(8, 1'b1);
    settle();
    chk(empty_n == 1'b1,        "R5 data present", empty_n, 1);
    chk(almost_empty_n == 1'b0, "R3 ae at 8 words", almost_empty_n, 0);
    wr_burst(1, 1'b1);
    settle();
    chk(almost_empty_n == 1'b1, "R9 ae at 9 words", almost_empty_n, 1);
    chk(almost_full_n == 1'b1,  "R10 af at 9 words", almost_full_n, 1);

    // R1: reset request while host selected is ignored
    do_reset(1'b0);
    chk(empty_n == 1'b1,        "R1 empty_n kept", empty_n, 1);
    chk(almost_empty_n == 1'b1, "R1 ae kept", almost_empty_n, 1);

    rd_drain(20);
    settle();
    chk(pops == 9,        "R1 words survive", pops, 9);
    chk(empty_n == 1'b0,  "R8 empty after drain", empty_n, 0);

    // R8: reads while empty are discarded
    rd_drain(4);
    settle();
    chk(empty_n == 1'b0, "R8 still empty", empty_n, 0);
    wr_burst(1, 1'b1);
    settle();
    chk(empty_n == 1'b1, "R8 one word", empty_n, 1);
    rd_drain(4);
    settle();
    chk(pops == 10, "R8 pointer intact", pops, 10);

    // R6 / R7 / R10: fill to capacity
    wr_burst(DEPTH - 9, 1'b1);
    settle();
    chk(almost_full_n == 1'b1, "R10 free 9", almost_full_n, 1);
    wr_burst(1, 1'b1);
    settle();
    chk(almost_full_n == 1'b0, "R10 free 8", almost_full_n, 0);
    wr_burst(7, 1'b1);
    settle();
    chk(full_n == 1'b1, "R6 DEPTH-1 words", full_n, 1);
    wr_burst(1, 1'b1);
    settle();
    chk(full_n == 1'b0, "R6 DEPTH words", full_n, 0);
    wr_burst(1, 1'b0);
    settle();
    chk(full_n == 1'b0, "R7 still full", full_n, 0);
    rd_drain(DEPTH + 40);
    settle();
    chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    chk(pops == 10 + DEPTH, "R7 extra write dropped", pops, 10 + DEPTH);
    chk(empty_n == 1'b0, "R7 empty after drain", empty_n, 0);

    // R11: program new thresholds
    load_off(1'b0, 2);
    load_off(1'b1, 3);
    wr_burst(2, 1'b1);
    settle();
    chk(almost_empty_n == 1'b0, "R11 ae at 2", almost_empty_n, 0);
    wr_burst(1, 1'b1);
    settle();
    chk(almost_empty_n == 1'b1, "R11 ae at 3", almost_empty_n, 1);
    wr_burst(DEPTH - 7, 1'b1);
    settle();
    chk(almost_full_n == 1'b1, "R11 af free 4", almost_full_n, 1);
    wr_burst(1, 1'b1);
    settle();
    chk(almost_full_n == 1'b0, "R11 af free 3", almost_full_n, 0);
    rd_drain(DEPTH + 40);
    settle();
    chk(exp_q.size() == 0, "R5 all read", exp_q.size(), 0);

    // R3: reset restores offsets to 8
    do_reset(1'b1);
    chk(empty_n == 1'b0, "R2 empty after reset", empty_n, 0);
    wr_burst(8, 1'b1);
    settle();
    chk(almost_empty_n == 1'b0, "R3 ae offset 8 again", almost_empty_n, 0);
    wr_burst(1, 1'b1);
    settle();
    chk(almost_empty_n == 1'b1, "R3 ae 9 words", almost_empty_n, 1);
    rd_drain(20);
    settle();
    chk(exp_q.size() == 0, "R5 final drain", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule